// File: doc/BRIEF.md
# Frame Loss Resync Handshake Controller

This block supervises frame alignment on a receive parallel line interface fed by an external deserializer. An upstream pattern checker reports the result of each framing-pattern check with a one-cycle strobe and a good/bad flag. After a run of consecutive bad checks the block raises its out-of-frame output. That rising edge, or the high level, tells the deserializer to search for the frame pattern again.

While the output is high the block waits for the deserializer's one-cycle frame pulse. It then judges the first framing check that follows. A good check ends the episode and the output falls for good. A bad check, or three frame periods with no frame pulse, makes the block pulse the output low for two cycles and raise it again, which gives the deserializer a new edge. The block runs in the byte clock domain, 77.76 MHz at the STS-12/STM-4 rate. A frame-period tick marks each 125 µs frame and is used only to time the missing-pulse timeout.

Top module: `oof_resync_ctrl`

## Requirements
- R1: After reset `oof_o` is low, the block is in frame and the consecutive-bad count is zero.
- R2: In frame, `oof_o` rises in the cycle after the n-th consecutive bad check (`chk_valid_i`=1, `chk_good_i`=0). n is 4 when the threshold select is 0 and 5 when it is 1.
- R3: In frame, a good check (`chk_valid_i`=1, `chk_good_i`=1) clears the consecutive-bad count.
- R4: The threshold select is captured while the consecutive-bad count is zero, at the first bad check of a run. Changing it later in the same run does not change that run's n.
- R5: While `oof_o` is high and no frame pulse has been seen, `frame_pulse_i` arms verification and `oof_o` stays high. Framing checks made before the pulse are ignored.
- R6: If the first check after an honored frame pulse is good, `oof_o` falls in the next cycle and stays low.
- R7: If the first check after an honored frame pulse is bad, `oof_o` is low for exactly two cycles and then high again.
- R8: If three `frame_tick_i` pulses arrive after a rising edge of `oof_o` with no frame pulse, `oof_o` is low for exactly two cycles and then high again. Every rising edge, including a retry edge, restarts the tick count.
- R9: Frame pulses and framing checks that arrive during the two-cycle low retrigger pulse are ignored.
- R10: A frame pulse arriving in the same cycle as the timeout-expiring tick takes priority: `oof_o` stays high and verification is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | One-cycle strobe: a framing check result is present |
| chk_good_i | input | 1 | Check result, 1 = framing pattern correct |
| frame_pulse_i | input | 1 | One-cycle resync pulse from the deserializer |
| frame_tick_i | input | 1 | One-cycle pulse per frame period |
| thr_sel_i | input | 1 | Bad-run threshold: 0 = 4 checks, 1 = 5 checks |
| oof_o | output | 1 | Out-of-frame request to the deserializer |

## Verification
A corrupted consecutive-bad count moves the rising edge of `oof_o` one or more checks away from the n-th bad check, so that fault shows at the threshold boundary within a single run. A wrong state or retrigger count shows within three cycles of a verification check or a timeout: the low pulse is one cycle too short or too long, or `oof_o` falls or stays high when it should not. A tick counter that fails to restart on retry edges shows only on the second timeout of an episode, so the tests run two timeouts back to back.

// File: rtl/oof_resync_pkg.sv
package oof_resync_pkg;
  typedef enum logic [1:0] {
    ST_IN_FRAME = 2'd0,
    ST_SEARCH   = 2'd1,
    ST_VERIFY   = 2'd2,
    ST_RETRIG   = 2'd3
  } oof_state_e;
endpackage

// File: rtl/oof_bad_run_cnt.sv
module oof_bad_run_cnt #(
  parameter int unsigned THR_LO = 4,
  parameter int unsigned THR_HI = 5,
  localparam int unsigned CW = $clog2(THR_HI + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic chk_valid_i,
  input  logic chk_good_i,
  input  logic thr_sel_i,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          thr_q;
  logic          thr_eff;
  logic          bad;

  // select is live only until the first bad check of a run (R4)
  assign thr_eff = (cnt_q == '0) ? thr_sel_i : thr_q;
  assign limit   = thr_eff ? CW'(THR_HI) : CW'(THR_LO);
  assign bad     = en_i & chk_valid_i & ~chk_good_i;
  assign hit_o   = bad & (cnt_q == limit - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= 1'b0;
    end else begin
      if (cnt_q == '0) thr_q <= thr_sel_i;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (chk_valid_i) begin
        if (chk_good_i || hit_o) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/oof_frame_timer.sv
module oof_frame_timer #(
  parameter int unsigned FRAMES = 3,
  localparam int unsigned TW = $clog2(FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == TW'(FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (run_i && tick_i && !expire_o) cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/oof_resync_fsm.sv
module oof_resync_fsm
  import oof_resync_pkg::*;
#(
  parameter int unsigned RETRIG_CYC = 2,
  localparam int unsigned RW = $clog2(RETRIG_CYC) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bad_hit_i,
  input  logic       chk_valid_i,
  input  logic       chk_good_i,
  input  logic       frame_pulse_i,
  input  logic       timeout_i,
  output logic       oof_o,
  output logic       in_frame_o,
  output logic       search_o,
  output logic       timer_clr_o,
  output oof_state_e state_o
);
  oof_state_e    state_q, state_d;
  logic [RW-1:0] rcnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IN_FRAME: if (bad_hit_i) state_d = ST_SEARCH;
      ST_SEARCH: begin
        if (frame_pulse_i)  state_d = ST_VERIFY;  // pulse beats timeout
        else if (timeout_i) state_d = ST_RETRIG;
      end
      ST_VERIFY: if (chk_valid_i) state_d = chk_good_i ? ST_IN_FRAME : ST_RETRIG;
      ST_RETRIG: if (rcnt_q == RW'(RETRIG_CYC - 1)) state_d = ST_SEARCH;
      default: state_d = ST_IN_FRAME;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IN_FRAME;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= (state_q == ST_RETRIG) ? rcnt_q + RW'(1) : '0;
    end
  end

  assign oof_o       = (state_q == ST_SEARCH) || (state_q == ST_VERIFY);
  assign in_frame_o  = (state_q == ST_IN_FRAME);
  assign search_o    = (state_q == ST_SEARCH);
  assign timer_clr_o = (state_d == ST_SEARCH) && (state_q != ST_SEARCH);
  assign state_o     = state_q;
endmodule

// File: rtl/oof_resync_ctrl.sv
module oof_resync_ctrl
  import oof_resync_pkg::*;
#(
  parameter int unsigned THR_LO     = 4,
  parameter int unsigned THR_HI     = 5,
  parameter int unsigned TO_FRAMES  = 3,
  parameter int unsigned RETRIG_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_valid_i,
  input  logic chk_good_i,
  input  logic frame_pulse_i,
  input  logic frame_tick_i,
  input  logic thr_sel_i,
  output logic oof_o
);
  oof_state_e state_q;
  logic in_frame, searching, timer_clr, bad_hit, timeout;

  oof_bad_run_cnt #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_bad (
    .clk_i, .rst_ni,
    .en_i        (in_frame),
    .chk_valid_i,
    .chk_good_i,
    .thr_sel_i,
    .hit_o       (bad_hit)
  );

  oof_frame_timer #(.FRAMES(TO_FRAMES)) u_timer (
    .clk_i, .rst_ni,
    .clr_i    (timer_clr),
    .run_i    (searching),
    .tick_i   (frame_tick_i),
    .expire_o (timeout)
  );

  oof_resync_fsm #(.RETRIG_CYC(RETRIG_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .bad_hit_i   (bad_hit),
    .chk_valid_i,
    .chk_good_i,
    .frame_pulse_i,
    .timeout_i   (timeout),
    .oof_o,
    .in_frame_o  (in_frame),
    .search_o    (searching),
    .timer_clr_o (timer_clr),
    .state_o     (state_q)
  );
endmodule

// File: rtl/oof_resync_chk.sv
module oof_resync_chk
  import oof_resync_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oof_o,
  input logic       chk_valid_i,
  input logic       chk_good_i,
  input logic       frame_pulse_i,
  input oof_state_e state_i
);
  // R1
  a_r1_low_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IN_FRAME) |-> !oof_o);

  // R2 / R8: a rise follows a bad check in frame or the end of a retrigger
  a_r2_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oof_o) |-> ($past(state_i) == ST_RETRIG) ||
                     ($past(state_i) == ST_IN_FRAME && $past(chk_valid_i) && !$past(chk_good_i)));

  // R6
  a_r6_good_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_VERIFY && chk_valid_i && chk_good_i) |=> (state_i == ST_IN_FRAME && !oof_o));

  // R7
  a_r7_bad_retries: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_VERIFY && chk_valid_i && !chk_good_i) |=> !oof_o ##1 !oof_o ##1 oof_o);

  // R8 / R7: retrigger low is two cycles wide
  a_r8_two_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oof_o) && state_i == ST_RETRIG) |-> ##1 !oof_o ##1 oof_o);

  // R9
  a_r9_pulse_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RETRIG && frame_pulse_i) |=> (state_i != ST_VERIFY));
endmodule

bind oof_resync_ctrl oof_resync_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .oof_o         (oof_o),
  .chk_valid_i   (chk_valid_i),
  .chk_good_i    (chk_good_i),
  .frame_pulse_i (frame_pulse_i),
  .state_i       (state_q)
);

// File: tb/oof_resync_ctrl_test.sv
`timescale 1ns/1ps
module oof_resync_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_valid = 1'b0, chk_good = 1'b0, pulse = 1'b0, tick = 1'b0, thr_sel = 1'b0;
  logic oof;
  int total = 0, bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  oof_resync_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .chk_valid_i(chk_valid), .chk_good_i(chk_good),
    .frame_pulse_i(pulse), .frame_tick_i(tick), .thr_sel_i(thr_sel), .oof_o(oof)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_oof(input logic exp, input string req);
    total++;
    if (oof !== exp) begin
      bad++;
      $display("FAIL %s: oof_o=%b expected %b at %0t", req, oof, exp, $time);
    end
  endtask

  task automatic do_chk(input logic good);
    chk_valid = 1'b1; chk_good = good; step(); chk_valid = 1'b0; chk_good = 1'b0;
  endtask
  task automatic do_pulse();
    pulse = 1'b1; step(); pulse = 1'b0;
  endtask
  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic enter_oof();
    thr_sel = 1'b0;
    for (int i = 0; i < 4; i++) do_chk(1'b0);
    expect_oof(1'b1, "R2 enter");
  endtask
  task automatic recover();
    do_pulse(); do_chk(1'b1);
    expect_oof(1'b0, "R6 recover");
    step(); expect_oof(1'b0, "R6 stays low");
  endtask

  task automatic t_reset();
    expect_oof(1'b0, "R1 reset");
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    expect_oof(1'b0, "R1 count starts at zero");
    do_chk(1'b0); expect_oof(1'b1, "R1 fourth bad");
    recover();
  endtask

  task automatic t_thresholds();
    thr_sel = 1'b0;
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    expect_oof(1'b0, "R2 n=4 three bad");
    do_chk(1'b0); expect_oof(1'b1, "R2 n=4 fourth bad");
    recover();
    thr_sel = 1'b1;
    for (int i = 0; i < 4; i++) do_chk(1'b0);
    expect_oof(1'b0, "R2 n=5 four bad");
    do_chk(1'b0); expect_oof(1'b1, "R2 n=5 fifth bad");
    recover();
  endtask

  task automatic t_good_clears();
    thr_sel = 1'b0;
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    do_chk(1'b1);
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    expect_oof(1'b0, "R3 good check cleared run");
    do_chk(1'b0); expect_oof(1'b1, "R3 fourth bad after clear");
    recover();
  endtask

  task automatic t_thr_change();
    thr_sel = 1'b0; do_chk(1'b0); thr_sel = 1'b1;
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    expect_oof(1'b1, "R4 run kept n=4");
    recover();
    thr_sel = 1'b1; do_chk(1'b0); thr_sel = 1'b0;
    for (int i = 0; i < 3; i++) do_chk(1'b0);
    expect_oof(1'b0, "R4 run kept n=5");
    do_chk(1'b0); expect_oof(1'b1, "R4 fifth bad");
    recover();
  endtask

  task automatic t_verify_bad();
    enter_oof();
    do_chk(1'b1); expect_oof(1'b1, "R5 check before pulse ignored");
    do_pulse(); expect_oof(1'b1, "R5 pulse keeps oof high");
    do_chk(1'b0); expect_oof(1'b0, "R7 low cycle 1");
    step(); expect_oof(1'b0, "R7 low cycle 2");
    step(); expect_oof(1'b1, "R7 high again");
    recover();
  endtask

  task automatic t_timeout();
    enter_oof();
    do_tick(); do_tick(); expect_oof(1'b1, "R8 two ticks");
    do_tick(); expect_oof(1'b0, "R8 low cycle 1");
    step(); expect_oof(1'b0, "R8 low cycle 2");
    step(); expect_oof(1'b1, "R8 retry edge");
    do_tick(); do_tick(); expect_oof(1'b1, "R8 count restarted");
    do_tick(); expect_oof(1'b0, "R8 second timeout");
    step(); step(); expect_oof(1'b1, "R8 second retry edge");
    recover();
  endtask

  task automatic t_ignore_retrig();
    enter_oof();
    for (int i = 0; i < 3; i++) do_tick();
    expect_oof(1'b0, "R9 in retrigger");
    pulse = 1'b1; chk_valid = 1'b1; chk_good = 1'b1; step();
    pulse = 1'b0; chk_valid = 1'b0; chk_good = 1'b0;
    expect_oof(1'b0, "R9 still low");
    step(); expect_oof(1'b1, "R9 high after retrigger");
    do_chk(1'b1); expect_oof(1'b1, "R9 pulse was ignored");
    recover();
  endtask

  task automatic t_race();
    enter_oof();
    do_tick(); do_tick();
    tick = 1'b1; pulse = 1'b1; step(); tick = 1'b0; pulse = 1'b0;
    expect_oof(1'b1, "R10 pulse wins");
    do_chk(1'b1); expect_oof(1'b0, "R10 verified");
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_thresholds();
    t_good_clears();
    t_thr_change();
    t_verify_bad();
    t_timeout();
    t_ignore_retrig();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: expired, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule